// File: doc/BRIEF.md
# Two-Port Hardware Lock Bank

This block provides a small bank of one-bit hardware locks shared by two independent ports, a left port and a right port. Each lock can be held by at most one port at a time. A port asks for a lock by writing 0 to it and gives it back by writing 1. If a port asks for a lock that the other side already holds, the request is remembered. When the holder gives the lock back, the lock goes straight to the waiting port, so the waiting port never has to poll and then race to claim it.

Each port reaches the lock bank only when its memory enable is inactive (high) and its lock select is active (low). The low address bits pick the lock, and bit 0 of the write data carries the value written. A read returns the port's own view of the chosen lock, repeated on every data bit: 0 means "this port holds it", 1 means "this port does not hold it". State changes on the rising clock edge. Reads are combinational from the current state.

Top module: `lock_bank`

## Requirements
- R1: After reset every lock is free and no request is pending, so both ports read 1 on every lock, and a lock that is claimed and then given back ends up free again.
- R2: A write changes nothing unless the port's memory enable is high and its lock select is low. A write with the memory enable low, or with the lock select high, leaves every lock unchanged.
- R3: A write with bit 0 = 0 to a free lock gives that port the token from the next clock edge. The holder then reads 0 and the other port reads 1. At no time do both ports hold the same lock.
- R4: A write of 0 to a lock held by the other port leaves ownership unchanged and records a pending request. A holder writing 0 again changes nothing.
- R5: When the holder writes 1 while the other port has a pending request, or while the other port writes 0 in the same cycle, the token passes directly to the other port.
- R6: When the holder writes 1 and no request from the other port is outstanding, the lock becomes free.
- R7: A write of 1 by a port that does not hold the lock never releases it. Such a write withdraws that port's own pending request, if it has one.
- R8: If both ports write 0 to a free lock in the same cycle, the left port gets the token and the right port's request is recorded as pending.
- R9: The lock is chosen by address bits 2..0 (lock index = address value). An access to one lock never changes another.
- R10: Only write data bit 0 is significant. The read value is placed on all 8 data bits (8'h00 for a holder, 8'hFF otherwise).
- R11: When a port is not performing a lock read (lock select high, memory enable low, or write enable low), its read data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_mem_n | input | 1 | Left memory enable, active low; must be high for lock access |
| l_lock_n | input | 1 | Left lock select, active low |
| l_wr_n | input | 1 | Left write enable, active low (high = read) |
| l_addr | input | 3 | Left lock index |
| l_wdata | input | 8 | Left write data (bit 0 used) |
| l_rdata | output | 8 | Left read data |
| r_mem_n | input | 1 | Right memory enable, active low; must be high for lock access |
| r_lock_n | input | 1 | Right lock select, active low |
| r_wr_n | input | 1 | Right write enable, active low (high = read) |
| r_addr | input | 3 | Right lock index |
| r_wdata | input | 8 | Right write data (bit 0 used) |
| r_rdata | output | 8 | Right read data |

## Verification
The hardest states to reach from the ports are the ones where both ports write to the same lock in the same clock cycle. This happens when both ask for a free lock at once, and when the holder gives a lock back in the same cycle that the other side asks for it. The bench reaches these states with a task that drives both ports on one clock edge. Pending requests cannot be read directly. The bench therefore shows them through their effect: after the holder releases, it checks which port now reads 0. This also covers a request that was withdrawn before the release.

// File: rtl/lock_bank_pkg.sv
package lock_bank_pkg;

   // Token holder of one lock
   typedef enum logic [1:0] {
      HOLD_NONE  = 2'd0,
      HOLD_LEFT  = 2'd1,
      HOLD_RIGHT = 2'd2
   } holder_t;

   // Decoded intent of one port toward one lock in one cycle
   typedef struct packed {
      logic claim;   // wrote 0
      logic give;    // wrote 1
   } intent_t;

endpackage

// File: rtl/lock_port_decode.sv
module lock_port_decode #(
   parameter int NUM_LOCKS = 8,
   parameter int DATA_W    = 8,
   localparam int ADDR_W   = $clog2(NUM_LOCKS)
) (
   input  logic              mem_n,
   input  logic              lock_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_LOCKS-1:0] claim,
   output logic [NUM_LOCKS-1:0] give,
   output logic              rd_en
);
   logic hit;
   logic wr_hit;

   // Lock space is reached only with memory enable inactive
   assign hit    = mem_n & ~lock_n;
   assign wr_hit = hit & ~wr_n;
   assign rd_en  = hit & wr_n;

   generate
      if (DATA_W > 1) begin : g_unused_hi
         logic unused_hi;
         assign unused_hi = ^wdata[DATA_W-1:1];
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_sel
         logic sel;
         assign sel      = wr_hit & (addr == ADDR_W'(i));
         assign claim[i] = sel & ~wdata[0];
         assign give[i]  = sel &  wdata[0];
      end
   endgenerate
endmodule

// File: rtl/lock_cell.sv
module lock_cell
   import lock_bank_pkg::*;
#(
   parameter bit LEFT_WINS_TIE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_claim,
   input  logic l_give,
   input  logic r_claim,
   input  logic r_give,
   output logic own_l,
   output logic own_r,
   output logic wait_l,
   output logic wait_r
);
   holder_t hold_q, hold_d;
   logic    wl_q, wl_d;
   logic    wr_q, wr_d;

   always_comb begin
      hold_d = hold_q;
      wl_d   = wl_q;
      wr_d   = wr_q;
      unique case (hold_q)
         HOLD_NONE: begin
            wl_d = 1'b0;
            wr_d = 1'b0;
            if (l_claim && (LEFT_WINS_TIE || !r_claim)) begin
               hold_d = HOLD_LEFT;
               wr_d   = r_claim;
            end else if (r_claim) begin
               hold_d = HOLD_RIGHT;
               wl_d   = l_claim;
            end
         end
         HOLD_LEFT: begin
            wl_d = 1'b0;
            if (l_give) begin
               hold_d = ((wr_q && !r_give) || r_claim) ? HOLD_RIGHT : HOLD_NONE;
               wr_d   = 1'b0;
            end else if (r_claim) begin
               wr_d = 1'b1;
            end else if (r_give) begin
               wr_d = 1'b0;
            end
         end
         HOLD_RIGHT: begin
            wr_d = 1'b0;
            if (r_give) begin
               hold_d = ((wl_q && !l_give) || l_claim) ? HOLD_LEFT : HOLD_NONE;
               wl_d   = 1'b0;
            end else if (l_claim) begin
               wl_d = 1'b1;
            end else if (l_give) begin
               wl_d = 1'b0;
            end
         end
         default: begin
            hold_d = HOLD_NONE;
            wl_d   = 1'b0;
            wr_d   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= HOLD_NONE;
         wl_q   <= 1'b0;
         wr_q   <= 1'b0;
      end else begin
         hold_q <= hold_d;
         wl_q   <= wl_d;
         wr_q   <= wr_d;
      end
   end

   assign own_l  = (hold_q == HOLD_LEFT);
   assign own_r  = (hold_q == HOLD_RIGHT);
   assign wait_l = wl_q;
   assign wait_r = wr_q;
endmodule

// File: rtl/lock_read_view.sv
module lock_read_view #(
   parameter int NUM_LOCKS = 8,
   parameter int DATA_W    = 8,
   localparam int ADDR_W   = $clog2(NUM_LOCKS)
) (
   input  logic [NUM_LOCKS-1:0] owned,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 rd_en,
   output logic [DATA_W-1:0]    rdata
);
   logic view;

   // 0 = this port holds the lock, 1 = it does not
   assign view  = ~owned[addr];
   assign rdata = rd_en ? {DATA_W{view}} : '0;
endmodule

// File: rtl/lock_bank.sv
module lock_bank #(
   parameter int NUM_LOCKS     = 8,
   parameter int DATA_W        = 8,
   parameter bit LEFT_WINS_TIE = 1'b1,
   localparam int ADDR_W       = $clog2(NUM_LOCKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_mem_n,
   input  logic              l_lock_n,
   input  logic              l_wr_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_mem_n,
   input  logic              r_lock_n,
   input  logic              r_wr_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   generate
      if (NUM_LOCKS < 2 || (1 << ADDR_W) != NUM_LOCKS) begin : g_bad_count
         $error("lock_bank: NUM_LOCKS must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("lock_bank: DATA_W must be at least 1");
      end
   endgenerate

   logic [NUM_LOCKS-1:0] l_claim, l_give, r_claim, r_give;
   logic [NUM_LOCKS-1:0] own_l, own_r, wait_l, wait_r;
   logic                 l_rd, r_rd;

   lock_port_decode #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_dec_l (
      .mem_n(l_mem_n), .lock_n(l_lock_n), .wr_n(l_wr_n), .addr(l_addr),
      .wdata(l_wdata), .claim(l_claim), .give(l_give), .rd_en(l_rd)
   );

   lock_port_decode #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_dec_r (
      .mem_n(r_mem_n), .lock_n(r_lock_n), .wr_n(r_wr_n), .addr(r_addr),
      .wdata(r_wdata), .claim(r_claim), .give(r_give), .rd_en(r_rd)
   );

   generate
      for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_cell
         lock_cell #(.LEFT_WINS_TIE(LEFT_WINS_TIE)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_claim(l_claim[i]), .l_give(l_give[i]),
            .r_claim(r_claim[i]), .r_give(r_give[i]),
            .own_l(own_l[i]), .own_r(own_r[i]),
            .wait_l(wait_l[i]), .wait_r(wait_r[i])
         );
      end
   endgenerate

   lock_read_view #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_view_l (
      .owned(own_l), .addr(l_addr), .rd_en(l_rd), .rdata(l_rdata)
   );

   lock_read_view #(.NUM_LOCKS(NUM_LOCKS), .DATA_W(DATA_W)) u_view_r (
      .owned(own_r), .addr(r_addr), .rd_en(r_rd), .rdata(r_rdata)
   );
endmodule

// File: rtl/lock_bank_chk.sv
module lock_bank_chk #(
   parameter int NUM_LOCKS     = 8,
   parameter bit LEFT_WINS_TIE = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LOCKS-1:0] l_claim,
   input logic [NUM_LOCKS-1:0] l_give,
   input logic [NUM_LOCKS-1:0] r_claim,
   input logic [NUM_LOCKS-1:0] r_give,
   input logic [NUM_LOCKS-1:0] own_l,
   input logic [NUM_LOCKS-1:0] own_r,
   input logic [NUM_LOCKS-1:0] wait_l,
   input logic [NUM_LOCKS-1:0] wait_r
);
   generate
      for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_p
         p_single_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(own_l[i] && own_r[i]));

         p_wait_on_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_r[i] |-> own_l[i]) and (wait_l[i] |-> own_r[i]));

         p_claim_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_l[i] && !own_r[i] && l_claim[i] && !r_claim[i]) |=> own_l[i]);

         p_keep_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && !l_give[i]) |=> own_l[i]);

         p_handoff_lr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && l_give[i] && ((wait_r[i] && !r_give[i]) || r_claim[i])) |=> own_r[i]);

         p_handoff_rl_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r[i] && r_give[i] && ((wait_l[i] && !l_give[i]) || l_claim[i])) |=> own_l[i]);

         p_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && l_give[i] && !wait_r[i] && !r_claim[i]) |=> (!own_l[i] && !own_r[i]));

         p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && r_give[i] && !l_give[i]) |=> (own_l[i] && !wait_r[i]));

         if (LEFT_WINS_TIE) begin : g_tie
            p_tie_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
               (!own_l[i] && !own_r[i] && l_claim[i] && r_claim[i]) |=> (own_l[i] && wait_r[i]));
         end
      end
   endgenerate
endmodule

bind lock_bank lock_bank_chk #(.NUM_LOCKS(NUM_LOCKS), .LEFT_WINS_TIE(LEFT_WINS_TIE)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_claim(l_claim), .l_give(l_give), .r_claim(r_claim), .r_give(r_give),
   .own_l(own_l), .own_r(own_r), .wait_l(wait_l), .wait_r(wait_r)
);

// File: tb/lock_bank_bench.sv
module lock_bank_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_mem_n = 1'b1, l_lock_n = 1'b1, l_wr_n = 1'b1;
   logic [2:0] l_addr = '0;
   logic [7:0] l_wdata = '0;
   logic [7:0] l_rdata;
   logic       r_mem_n = 1'b1, r_lock_n = 1'b1, r_wr_n = 1'b1;
   logic [2:0] r_addr = '0;
   logic [7:0] r_wdata = '0;
   logic [7:0] r_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lock_bank u_lock_bank (
      .clk(clk), .rst_n(rst_n),
      .l_mem_n(l_mem_n), .l_lock_n(l_lock_n), .l_wr_n(l_wr_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_mem_n(r_mem_n), .r_lock_n(r_lock_n), .r_wr_n(r_wr_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_all();
      l_mem_n = 1'b1; l_lock_n = 1'b1; l_wr_n = 1'b1;
      r_mem_n = 1'b1; r_lock_n = 1'b1; r_wr_n = 1'b1;
   endtask

   // side 0 = left, 1 = right; one write taking effect at the next rising edge
   task automatic wr_raw(bit side, bit mem_n, bit lock_n, int idx, logic [7:0] d);
      @(negedge clk);
      if (!side) begin
         l_mem_n = mem_n; l_lock_n = lock_n; l_wr_n = 1'b0;
         l_addr = 3'(idx); l_wdata = d;
      end else begin
         r_mem_n = mem_n; r_lock_n = lock_n; r_wr_n = 1'b0;
         r_addr = 3'(idx); r_wdata = d;
      end
      @(negedge clk);
      idle_all();
   endtask

   task automatic wr(bit side, int idx, logic [7:0] d);
      wr_raw(side, 1'b1, 1'b0, idx, d);
   endtask

   task automatic wr_both(int idx, logic [7:0] dl, logic [7:0] dr);
      @(negedge clk);
      l_mem_n = 1'b1; l_lock_n = 1'b0; l_wr_n = 1'b0; l_addr = 3'(idx); l_wdata = dl;
      r_mem_n = 1'b1; r_lock_n = 1'b0; r_wr_n = 1'b0; r_addr = 3'(idx); r_wdata = dr;
      @(negedge clk);
      idle_all();
   endtask

   // Read both ports' views of one lock; expected bits: 0 = holds, 1 = not
   task automatic rd_chk(string req, int idx, bit exp_l, bit exp_r);
      @(negedge clk);
      l_mem_n = 1'b1; l_lock_n = 1'b0; l_wr_n = 1'b1; l_addr = 3'(idx);
      r_mem_n = 1'b1; r_lock_n = 1'b0; r_wr_n = 1'b1; r_addr = 3'(idx);
      #1;
      check8({req, " left"},  l_rdata, {8{exp_l}});
      check8({req, " right"}, r_rdata, {8{exp_r}});
      idle_all();
   endtask

   task automatic t_reset();   // R1
      for (int i = 0; i < 8; i++) rd_chk("R1 reset free", i, 1'b1, 1'b1);
      wr(0, 0, 8'h00);
      wr(0, 0, 8'h01);
      rd_chk("R1 claim then give", 0, 1'b1, 1'b1);
   endtask

   task automatic t_qualify();   // R2
      wr_raw(0, 1'b0, 1'b0, 2, 8'h00);   // memory enable active: not a lock access
      rd_chk("R2 mem enable low", 2, 1'b1, 1'b1);
      wr_raw(1, 1'b1, 1'b1, 2, 8'h00);   // lock select inactive
      rd_chk("R2 lock select high", 2, 1'b1, 1'b1);
   endtask

   task automatic t_idle_read();   // R11
      wr(0, 1, 8'h00);               // left holds lock 1 so a view would be 00
      @(negedge clk);
      l_mem_n = 1'b1; l_lock_n = 1'b1; l_wr_n = 1'b1; l_addr = 3'd1;
      r_mem_n = 1'b0; r_lock_n = 1'b0; r_wr_n = 1'b1; r_addr = 3'd1;
      #1;
      check8("R11 select high", l_rdata, 8'h00);
      check8("R11 mem enable low", r_rdata, 8'h00);
      idle_all();
      wr(0, 1, 8'h01);
      rd_chk("R11 cleanup", 1, 1'b1, 1'b1);
   endtask

   task automatic t_claim();   // R3, R10
      wr(0, 2, 8'hFE);               // bit0 = 0 despite other bits set
      rd_chk("R3 R10 left holds", 2, 1'b0, 1'b1);
      wr(0, 2, 8'h01);               // bit0 = 1 releases
      rd_chk("R10 bit0 release", 2, 1'b1, 1'b1);
      wr(1, 2, 8'h00);
      rd_chk("R3 right holds", 2, 1'b1, 1'b0);
      wr(1, 2, 8'hFF);
      rd_chk("R6 right gives", 2, 1'b1, 1'b1);
   endtask

   task automatic t_contend();   // R4, R5, R6
      wr(0, 3, 8'h00);
      wr(1, 3, 8'h00);
      rd_chk("R4 request while held", 3, 1'b0, 1'b1);
      wr(0, 3, 8'h00);
      rd_chk("R4 holder claims again", 3, 1'b0, 1'b1);
      wr(0, 3, 8'h01);
      rd_chk("R5 handoff to waiter", 3, 1'b1, 1'b0);
      wr(1, 3, 8'h01);
      rd_chk("R6 free after give", 3, 1'b1, 1'b1);
   endtask

   task automatic t_nonholder();   // R7
      wr(0, 4, 8'h00);
      wr(1, 4, 8'h01);
      rd_chk("R7 non-holder give ignored", 4, 1'b0, 1'b1);
      wr(1, 4, 8'h00);
      wr(1, 4, 8'h01);               // withdraw pending request
      wr(0, 4, 8'h01);
      rd_chk("R7 withdrawn request", 4, 1'b1, 1'b1);
   endtask

   task automatic t_tie();   // R8
      wr_both(5, 8'h00, 8'h00);
      rd_chk("R8 left wins tie", 5, 1'b0, 1'b1);
      wr(0, 5, 8'h01);
      rd_chk("R8 right was pending", 5, 1'b1, 1'b0);
      wr(1, 5, 8'h01);
      rd_chk("R8 cleanup", 5, 1'b1, 1'b1);
   endtask

   task automatic t_same_edge();   // R5
      wr(1, 6, 8'h00);
      wr_both(6, 8'h00, 8'h01);      // right gives while left claims
      rd_chk("R5 same-cycle handoff", 6, 1'b0, 1'b1);
      wr(0, 6, 8'h01);
      rd_chk("R6 no waiter frees", 6, 1'b1, 1'b1);
   endtask

   task automatic t_independent();   // R9
      wr(0, 1, 8'h00);
      wr(1, 7, 8'h00);
      rd_chk("R9 lock1", 1, 1'b0, 1'b1);
      rd_chk("R9 lock7", 7, 1'b1, 1'b0);
      for (int i = 2; i < 7; i++) rd_chk("R9 others free", i, 1'b1, 1'b1);
      rd_chk("R9 lock0 free", 0, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_qualify();
      t_idle_read();
      t_claim();
      t_contend();
      t_nonholder();
      t_tie();
      t_same_edge();
      t_independent();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule